// File: doc/BRIEF.md
# Loadable Pseudo-Random Shift Generator

This block is an eight-stage linear feedback shift register that serves as a pseudo-random number source. Each stage has a multiplexer in front of its flip-flop. The multiplexer selects either a bit of an external seed word or the value shifted in from the neighbouring stage, so software-visible logic can start the sequence from any chosen point.

While `step_en` is high, the register advances once per clock. The newest bit enters at the most significant end and the contents move toward bit 0. The entering bit is the exclusive OR of the stages picked by the fixed feedback polynomial 1 + D^4 + D^5 + D^6 + D^8. This polynomial is maximal-length, so any nonzero seed walks through all 255 nonzero states before it repeats.

Reset clears the register to the all-zero state. That state maps onto itself, so the generator stays at zero until a seed is loaded.

Top module: `lfsr_prng`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) sets `state` to 0x00 on that edge, regardless of `load` and `step_en`.
- R2: With `rst` low and `load` high at a rising edge, `state` takes the value of `seed` on that edge, whatever `step_en` is.
- R3: With `rst` and `load` low and `step_en` high, the new state is {f, old[7:1]}, where f = old[4] ^ old[3] ^ old[2] ^ old[0]. Bit 7 receives the new bit and bit 0 holds the oldest.
- R4: With `rst`, `load` and `step_en` all low, `state` keeps its value.
- R5: Starting from seed 0x01 and stepping continuously, the state returns to 0x01 after exactly 255 steps and shows no repeated value before that.
- R6: From state 0x00, stepping leaves the state at 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| step_en | input | 1 | Advance the register by one step |
| load | input | 1 | Parallel load of the seed |
| seed | input | 8 | Initial value for the parallel load |
| state | output | 8 | Current register contents |

## Verification
The hardest condition to reach from the ports is a complete, uninterrupted walk through the cycle. Seeing that the period is exactly 255, with no early repeat, needs the load to land on a known seed and then 255 consecutive enabled edges with no stray load. The bench does this as one directed run, and keeps a table of every state visited to catch any repeat. Around that run, random mixes of reset, load, enable and seed are checked against a bench model of the recurrence. The zero lock-up is reached on purpose, by stepping straight after reset.

// File: rtl/lfsr_prng.sv
module lfsr_prng #(
  parameter int WIDTH = 8,
  parameter logic [WIDTH:1] COEF = 8'hB8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step_en,
  input  logic             load,
  input  logic [WIDTH-1:0] seed,
  output logic [WIDTH-1:0] state
);

  logic [WIDTH-1:0] q;
  logic             fb;
  logic [WIDTH-1:0] shifted;

  always_comb begin
    fb = 1'b0;
    for (int i = 1; i <= WIDTH; i++)
      if (COEF[i]) fb = fb ^ q[WIDTH-i];
  end

  assign shifted = {fb, q[WIDTH-1:1]};

  always_ff @(posedge clk) begin
    if (rst)          q <= '0;
    else if (load)    q <= seed;
    else if (step_en) q <= shifted;
  end

  assign state = q;

  p_reset_clear_r1: assert property (@(posedge clk) rst |=> state == '0);
  p_load_seed_r2: assert property (@(posedge clk) disable iff (rst)
    load |=> state == $past(seed));
  p_shift_move_r3: assert property (@(posedge clk) disable iff (rst)
    (!load && step_en) |=> state[WIDTH-2:0] == $past(state[WIDTH-1:1]));
  p_idle_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (!load && !step_en) |=> $stable(state));
  p_zero_lock_r6: assert property (@(posedge clk) disable iff (rst)
    (!load && state == '0) |=> state == '0);

endmodule

// File: tb/test_lfsr_prng.sv
module test_lfsr_prng;
  logic clk = 1'b0;
  logic rst, step_en, load;
  logic [7:0] seed;
  logic [7:0] state;
  logic [7:0] model;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  lfsr_prng i_lfsr_prng (.clk(clk), .rst(rst), .step_en(step_en),
    .load(load), .seed(seed), .state(state));

  function automatic logic [7:0] advance(input logic [7:0] s);
    return {s[4] ^ s[3] ^ s[2] ^ s[0], s[7:1]};
  endfunction

  task automatic check(input string req, input logic [7:0] exp);
    checks++;
    if (state !== exp) begin
      errors++;
      $display("FAIL %s: state=%02h expected=%02h", req, state, exp);
    end
  endtask

  task automatic cycle(input logic r, input logic l, input logic e,
                       input logic [7:0] s, input string req);
    @(negedge clk);
    rst = r; load = l; step_en = e; seed = s;
    if (r) model = 8'h00;
    else if (l) model = s;
    else if (e) model = advance(model);
    @(posedge clk);
    #1;
    check(req, model);
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: state=%02h expected=finished", state);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    bit seen [256];
    int unused_seed;
    logic r, l, e;
    logic [7:0] s;
    rst = 1'b1; load = 1'b0; step_en = 1'b0; seed = 8'h00; model = 8'h00;
    unused_seed = $urandom(32'd448);
    cycle(1, 1, 1, 8'h5A, "R1 reset beats load");
    cycle(0, 0, 1, 8'h00, "R6 zero lock");
    cycle(0, 0, 1, 8'h00, "R6 zero lock");
    cycle(0, 1, 1, 8'hC3, "R2 load beats enable");
    cycle(0, 0, 0, 8'hFF, "R4 hold");
    cycle(0, 0, 1, 8'h00, "R3 step");
    cycle(0, 1, 0, 8'hFF, "R2 load");
    cycle(0, 0, 1, 8'h00, "R3 step from FF");
    cycle(1, 0, 1, 8'h00, "R1 reset");

    cycle(0, 1, 0, 8'h01, "R2 load seed 01");
    for (int k = 0; k < 256; k++) seen[k] = 1'b0;
    seen[8'h01] = 1'b1;
    for (int k = 1; k <= 255; k++) begin
      cycle(0, 0, 1, 8'h00, "R5 period walk");
      if (k < 255) begin
        checks++;
        if (seen[state] || state == 8'h00) begin
          errors++;
          $display("FAIL R5: state=%02h repeated at step %0d expected=new", state, k);
        end
        seen[state] = 1'b1;
      end
    end
    checks++;
    if (state !== 8'h01) begin
      errors++;
      $display("FAIL R5: state=%02h after 255 steps expected=01", state);
    end

    for (int k = 0; k < 400; k++) begin
      r = ($urandom % 16) == 0;
      l = ($urandom % 6) == 0;
      e = ($urandom % 3) != 0;
      s = 8'($urandom);
      cycle(r, l, e, s, "R1 R2 R3 R4 random mix");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule